// File: doc/BRIEF.md
# Ones-Density Monitor and Enforcer

This block watches two serial line streams, one for transmit and one for receive, one bit per strobe. It checks each stream against two density rules. The first rule allows no run of more than fifteen zeros. The second covers sliding windows: for every N from 1 to 23, any 8·(N+1) consecutive bits must hold at least N ones. Each stream has its own violation flag. The flag is sticky: it holds until a clear pulse arrives or the block is reset.

The transmit path has an enforcement option. When it is on, the block turns a zero into a one whenever passing the zero would break either rule, given the bits already sent. Every other bit goes through unchanged. The corrected bit leaves through a register, so the output lags the input by one accepted bit. The transmit monitor looks at the corrected stream, not at the raw input. Enforcement is normally left off when the line code already guarantees density, for example a zero-substitution code.

Top module: `ones_density_guard`

## Requirements
- R1: After reset, tx_out, tx_viol and rx_viol are all 0, and every history, run counter and window counter starts empty.
- R2: On a stream, accepting a zero that makes 16 or more consecutive zeros raises that stream's violation event at that clock edge.
- R3: For each N from 1 to 23, when an accepted bit completes a window of 8·(N+1) bits that holds fewer than N ones, a violation event is raised. A window is checked only once at least 8·(N+1) bits have been accepted on that stream since reset.
- R4: The receive flag depends only on the receive stream. The transmit flag depends only on the transmitted output stream. Both streams are monitored whatever the state of enforce_en.
- R5: A violation flag becomes 1 at the edge where its event occurs and then holds. A 1 on viol_clr clears both flags at the next edge. An event in the same cycle as a clear wins, and leaves its flag at 1.
- R6: A stream accepts a bit only on an edge where its valid input is 1. On any other edge, tx_out and both monitors keep their state.
- R7: With enforce_en at 0, tx_out after an accepted transmit edge equals the tx_bit that was accepted there.
- R8: With enforce_en at 1, an accepted tx_bit of 0 goes out as 1 exactly when a 0 would raise a transmit violation under R2 or R3. An accepted 1 always goes out as 1.
- R9: If enforce_en is held at 1 from the end of reset, tx_viol stays 0 for any transmit data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enforce_en | input | 1 | Enables density correction on the transmit path |
| viol_clr | input | 1 | One-cycle pulse that clears both violation flags |
| tx_valid | input | 1 | Transmit bit strobe |
| tx_bit | input | 1 | Transmit data bit |
| rx_valid | input | 1 | Receive bit strobe |
| rx_bit | input | 1 | Receive data bit |
| tx_out | output | 1 | Registered transmit bit after correction |
| tx_viol | output | 1 | Sticky transmit density violation flag |
| rx_viol | output | 1 | Sticky receive density violation flag |

## Verification
The bench goes after the first fill of each window. A design that checked windows before they had filled would flag a short start-up pattern such as fifteen zeros and a one. A design that dropped the wrong history bit would miss a stream with one one in every twelve bits, which stays inside the zero-run limit but starves the long windows. On the enforced path, an all-zero input must come out with a forced one on exactly the sixteenth bit and at the later window boundaries. A correction decision taken one bit late would leave a seventeen-bit gap and set tx_viol. The bench also drives a clear and an event in the same cycle, and a mix of idle strobes during random runs. A flag with the wrong priority would drop an event, and a monitor that counted idle cycles would drift away from the bit-by-bit reference.

// File: rtl/odg_pkg.sv
package odg_pkg;
  // Length of density window n (n counts from 1) for a given group size.
  function automatic int unsigned win_len(int unsigned n, int unsigned grp);
    return grp * (n + 1);
  endfunction

  // Minimum number of ones demanded in window n.
  function automatic int unsigned win_min(int unsigned n);
    return n;
  endfunction
endpackage

// File: rtl/density_monitor.sv
module density_monitor #(
  parameter int unsigned GROUP = 8,
  parameter int unsigned NWIN  = 23,
  parameter int unsigned MAXZ  = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_in,
  output logic zero_ok,
  output logic viol_evt
);
  import odg_pkg::*;

  localparam int unsigned HIST = win_len(NWIN, GROUP);
  localparam int unsigned CW   = $clog2(HIST + 1);
  localparam int unsigned ZW   = $clog2(MAXZ + 2);

  logic [HIST-1:0] hist_q;
  logic [CW-1:0]   seen_q;
  logic [ZW-1:0]   zrun_q;
  logic [NWIN-1:0] short_if_zero;
  logic [NWIN-1:0] short_now;
  logic            run_full;

  assign run_full = (zrun_q >= ZW'(MAXZ));

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam int unsigned LEN  = win_len(w + 1, GROUP);
    localparam int unsigned MINV = win_min(w + 1);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] keep;
    logic [CW-1:0] nxt;
    logic          filled;

    assign keep   = cnt_q - {{(CW-1){1'b0}}, hist_q[LEN-1]};
    assign nxt    = keep + {{(CW-1){1'b0}}, bit_in};
    assign filled = (seen_q >= CW'(LEN - 1));
    assign short_if_zero[w] = filled && (keep < CW'(MINV));
    assign short_now[w]     = filled && (nxt < CW'(MINV));

    always_ff @(posedge clk) begin
      if (!rst_n)         cnt_q <= '0;
      else if (bit_valid) cnt_q <= nxt;
    end

    // R3: a running count never exceeds its window length
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(LEN));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      seen_q <= '0;
      zrun_q <= '0;
    end else if (bit_valid) begin
      hist_q <= {hist_q[HIST-2:0], bit_in};
      if (seen_q != CW'(HIST)) seen_q <= seen_q + 1'b1;
      if (bit_in)                     zrun_q <= '0;
      else if (zrun_q != ZW'(MAXZ+1)) zrun_q <= zrun_q + 1'b1;
    end
  end

  assign zero_ok  = !run_full && !(|short_if_zero);
  assign viol_evt = bit_valid && ((!bit_in && run_full) || (|short_now));

  // R6: idle edges leave the monitor state untouched
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(seen_q) && $stable(zrun_q) && $stable(hist_q));
  // R2: an accepted one always ends a zero run
  a_r2_run_reset: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && bit_in |=> zrun_q == '0);
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end

  a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr |=> flag);
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !set_evt |=> !flag);
endmodule

// File: rtl/pulse_enforcer.sv
module pulse_enforcer (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_in,
  input  logic enable,
  input  logic zero_ok,
  output logic next_bit,
  output logic out_bit
);
  logic force_one;

  assign force_one = enable && !zero_ok;
  assign next_bit  = bit_in || force_one;

  always_ff @(posedge clk) begin
    if (!rst_n)         out_bit <= 1'b0;
    else if (bit_valid) out_bit <= next_bit;
  end

  a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(out_bit));
  a_r7_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && !enable |=> out_bit == $past(bit_in));
  a_r8_forced: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && enable && !zero_ok |=> out_bit);
  a_r8_keep_ones: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && bit_in |=> out_bit);
endmodule

// File: rtl/ones_density_guard.sv
module ones_density_guard #(
  parameter int unsigned GROUP = 8,
  parameter int unsigned NWIN  = 23,
  parameter int unsigned MAXZ  = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enforce_en,
  input  logic viol_clr,
  input  logic tx_valid,
  input  logic tx_bit,
  input  logic rx_valid,
  input  logic rx_bit,
  output logic tx_out,
  output logic tx_viol,
  output logic rx_viol
);
  logic tx_zero_ok, tx_evt, tx_next;
  logic rx_zero_ok, rx_evt;
  logic enf_clean_q;

  pulse_enforcer u_enf (
    .clk(clk), .rst_n(rst_n), .bit_valid(tx_valid), .bit_in(tx_bit),
    .enable(enforce_en), .zero_ok(tx_zero_ok),
    .next_bit(tx_next), .out_bit(tx_out)
  );

  density_monitor #(.GROUP(GROUP), .NWIN(NWIN), .MAXZ(MAXZ)) u_txmon (
    .clk(clk), .rst_n(rst_n), .bit_valid(tx_valid), .bit_in(tx_next),
    .zero_ok(tx_zero_ok), .viol_evt(tx_evt)
  );

  density_monitor #(.GROUP(GROUP), .NWIN(NWIN), .MAXZ(MAXZ)) u_rxmon (
    .clk(clk), .rst_n(rst_n), .bit_valid(rx_valid), .bit_in(rx_bit),
    .zero_ok(rx_zero_ok), .viol_evt(rx_evt)
  );

  sticky_flag u_txflag (
    .clk(clk), .rst_n(rst_n), .set_evt(tx_evt), .clr(viol_clr), .flag(tx_viol)
  );

  sticky_flag u_rxflag (
    .clk(clk), .rst_n(rst_n), .set_evt(rx_evt), .clr(viol_clr), .flag(rx_viol)
  );

  // Tracks whether enforcement has been on at every edge since reset.
  always_ff @(posedge clk) begin
    if (!rst_n)           enf_clean_q <= 1'b1;
    else if (!enforce_en) enf_clean_q <= 1'b0;
  end

  // R9: continuous enforcement since reset never produces a transmit event
  a_r9_enforced_clean: assert property (@(posedge clk) disable iff (!rst_n)
    enf_clean_q && enforce_en |-> !tx_evt);
  // R2/R3: a zero judged safe by a monitor raises no event when accepted
  a_r4_rx_safe_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_bit && rx_zero_ok |-> !rx_evt);
  a_r4_tx_safe_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_next && tx_zero_ok |-> !tx_evt);
  // R1: outputs are clear in the first cycle after reset
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> !tx_out && !tx_viol && !rx_viol);
endmodule

// File: tb/tb_ones_density_guard.sv
module tb_ones_density_guard;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enforce_en = 1'b0, viol_clr = 1'b0;
  logic tx_valid = 1'b0, tx_bit = 1'b0, rx_valid = 1'b0, rx_bit = 1'b0;
  logic tx_out, tx_viol, rx_viol;

  int checks = 0, errors = 0;
  bit en_sel = 0;
  bit tq[$];
  bit rq[$];
  bit exp_out = 0, exp_txf = 0, exp_rxf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ones_density_guard dut (
    .clk(clk), .rst_n(rst_n), .enforce_en(enforce_en), .viol_clr(viol_clr),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .tx_out(tx_out), .tx_viol(tx_viol), .rx_viol(rx_viol)
  );

  // True when appending b to history q breaks the zero-run or a window rule.
  function automatic bit breaks(bit q[$], bit b);
    int sz;
    q.push_back(b);
    sz = q.size();
    if (sz >= 16) begin
      int ones = 0;
      for (int i = sz - 16; i < sz; i++) ones += q[i];
      if (ones == 0) return 1'b1;
    end
    for (int n = 1; n <= 23; n++) begin
      int len = 8 * (n + 1);
      if (sz >= len) begin
        int c = 0;
        for (int i = sz - len; i < sz; i++) c += q[i];
        if (c < n) return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tx_valid = 0; rx_valid = 0; viol_clr = 0; enforce_en = en_sel;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    tq.delete(); rq.delete();
    exp_out = 0; exp_txf = 0; exp_rxf = 0;
  endtask

  // One clock: drive at the falling edge, update the model, compare after the rising edge.
  task automatic step(string req, bit tv, bit tb, bit rv, bit rb, bit clr);
    bit tset, rset, ob;
    @(negedge clk);
    tx_valid = tv; tx_bit = tb; rx_valid = rv; rx_bit = rb;
    viol_clr = clr; enforce_en = en_sel;
    @(posedge clk);
    #1;
    tset = 0; rset = 0;
    if (tv) begin
      ob = tb;
      if (en_sel && !tb && breaks(tq, 1'b0)) ob = 1'b1;
      tset = breaks(tq, ob);
      tq.push_back(ob);
      if (tq.size() > 192) void'(tq.pop_front());
      exp_out = ob;
    end
    if (rv) begin
      rset = breaks(rq, rb);
      rq.push_back(rb);
      if (rq.size() > 192) void'(rq.pop_front());
    end
    exp_txf = tset ? 1'b1 : (clr ? 1'b0 : exp_txf);
    exp_rxf = rset ? 1'b1 : (clr ? 1'b0 : exp_rxf);
    chk(req, "tx_out", tx_out, exp_out);
    chk(req, "tx_viol", tx_viol, exp_txf);
    chk(req, "rx_viol", rx_viol, exp_rxf);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h0d5e_1a7e));
    en_sel = 0;
    do_reset();
    #1;
    // R1: reset state
    chk("R1", "tx_out", tx_out, 0);
    chk("R1", "tx_viol", tx_viol, 0);
    chk("R1", "rx_viol", rx_viol, 0);

    // R3: fifteen zeros then a one fills only the 16-bit window; no flag
    for (int i = 0; i < 15; i++) step("R3", 0, 0, 1, 0, 0);
    step("R3", 0, 0, 1, 1, 0);
    chk("R3", "rx_viol early window", rx_viol, 0);

    // R2: sixteen zeros from reset raise the receive flag on the sixteenth
    do_reset();
    for (int i = 0; i < 15; i++) step("R2", 0, 0, 1, 0, 0);
    chk("R2", "rx_viol after 15 zeros", rx_viol, 0);
    step("R2", 0, 0, 1, 0, 0);
    chk("R2", "rx_viol after 16 zeros", rx_viol, 1);
    chk("R4", "tx_viol untouched by rx", tx_viol, 0);

    // R5: flag holds over idle, clears on pulse, set beats clear
    repeat (5) step("R5", 0, 0, 0, 0, 0);
    chk("R5", "rx_viol held", rx_viol, 1);
    step("R5", 0, 0, 0, 0, 1);
    chk("R5", "rx_viol cleared", rx_viol, 0);
    step("R5", 0, 0, 1, 0, 1);
    chk("R5", "set wins over clear", rx_viol, 1);

    // R3: one in twelve obeys the zero run but starves long windows
    do_reset();
    for (int i = 1; i <= 24; i++) step("R3", 0, 0, 1, (i % 12) == 0, 0);
    chk("R3", "rx_viol after 24 bits", rx_viol, 0);
    for (int i = 25; i <= 240; i++) step("R3", 0, 0, 1, (i % 12) == 0, 0);
    chk("R3", "rx_viol sparse stream", rx_viol, 1);

    // R3/R7: one in eight is compliant on both paths, passed through unchanged
    do_reset();
    for (int i = 1; i <= 400; i++) step("R7", 1, (i % 8) == 0, 1, (i % 8) == 0, 0);
    chk("R3", "rx_viol dense stream", rx_viol, 0);
    chk("R7", "tx_viol dense stream", tx_viol, 0);

    // R7/R4: unenforced zeros reach the line and set the transmit flag
    for (int i = 0; i < 20; i++) step("R7", 1, 0, 0, 0, 0);
    chk("R7", "tx_out raw zero", tx_out, 0);
    chk("R4", "tx_viol raw stream", tx_viol, 1);
    chk("R4", "rx_viol independent", rx_viol, 0);

    // R8/R9: all-zero input under enforcement gets a one on the sixteenth bit
    en_sel = 1;
    do_reset();
    for (int i = 1; i <= 15; i++) step("R8", 1, 0, 0, 0, 0);
    chk("R8", "tx_out bit 15", tx_out, 0);
    step("R8", 1, 0, 0, 0, 0);
    chk("R8", "tx_out bit 16 forced", tx_out, 1);
    for (int i = 17; i <= 600; i++) step("R9", 1, 0, 0, 0, 0);
    chk("R9", "tx_viol all zero enforced", tx_viol, 0);

    // R9: sparse random transmit data under continuous enforcement
    do_reset();
    for (int i = 0; i < 1500; i++)
      step("R9", ($urandom % 10) < 8, ($urandom % 100) < 4, 0, 0, 0);
    chk("R9", "tx_viol random enforced", tx_viol, 0);

    // R6/R8/R4: random mix of strobes, densities, enforcement and clears
    en_sel = 0;
    do_reset();
    for (int seg = 0; seg < 8; seg++) begin
      int thr;
      case (seg % 4)
        0: thr = 3;
        1: thr = 10;
        2: thr = 30;
        default: thr = 60;
      endcase
      en_sel = seg[0];
      for (int i = 0; i < 500; i++)
        step("R6", ($urandom % 10) < 8, ($urandom % 100) < thr,
             ($urandom % 10) < 7, ($urandom % 100) < thr, ($urandom % 200) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule